// File: doc/BRIEF.md
# Configurable Bidirectional GPIO Port

This block is an eight-pin I/O port. It sits between a register bus and a row of tri-state pads. Each pin can be assigned to an on-chip peripheral. Otherwise it works as a general-purpose pin, and software chooses between a push-pull output and an open-drain output. An open-drain pin whose latch holds 1 does not drive the pad, so the same setting also serves as a high-impedance input.

Software uses four register slots. Three of them are read/write control words: peripheral-select, drive-style and output latch. The fourth returns the pad levels after a two-flop synchronizer. All pad drive outputs are combinational from the control registers and the peripheral inputs. A register write therefore reaches the pads right after the clock edge that stores it.

Top module: `gpio_port`

## Requirements
- R1: Synchronous active-high reset sets peripheral-select to 00h, drive-style to FFh and latch to FFh. Right after reset, every pad_oe bit is 0.
- R2: When a peripheral-select bit is 1, that pin's pad_out and pad_oe equal periph_out and periph_oe for the same bit, in the same cycle.
- R3: When a pin's peripheral-select bit is 0 and its drive-style bit is 0 (push-pull), pad_oe is 1 and pad_out equals the latch bit.
- R4: When a pin's peripheral-select bit is 0 and its drive-style bit is 1 (open-drain), pad_out is 0. With latch 0 the pin is driven low (pad_oe = 1).
- R5: An open-drain pin with latch 1 has pad_oe = 0 (high impedance, usable as an input).
- R6: While a pin's peripheral-select bit is 1, writes to drive-style and latch leave its pad_out and pad_oe unchanged. The stored values are still read back and take effect once the pin returns to GPIO use.
- R7: Reading the latch slot returns the stored latch value, whatever the pad levels are.
- R8: The pin-state slot returns pad_in delayed by two clock edges, in every mode. A change on pad_in is not visible after only one edge.
- R9: Register slots are addressed as 0 = peripheral-select, 1 = drive-style, 2 = latch, 3 = pin-state. A write with wr_en is stored on the next rising edge, and rdata shows the addressed slot combinationally.
- R10: A write to slot 3 changes none of the three control registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed slot |
| addr | input | 2 | Register slot select for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed slot |
| periph_out | input | 8 | Per-pin value from the peripheral |
| periph_oe | input | 8 | Per-pin output enable from the peripheral |
| pad_in | input | 8 | Pad level seen at the pad cell |
| pad_out | output | 8 | Value to the pad cell driver |
| pad_oe | output | 8 | Pad driver enable, 1 = drive |

## Verification
The bench sets up ports where pins of different kinds sit side by side. In one pattern some pins are push-pull and some are open-drain. In another, some pins belong to the peripheral and some are GPIO. A design that decoded the drive-style bit without looking at the latch bit would drive a high on open-drain pins, and this setup shows it. The bench writes the drive-style and latch slots while a pin belongs to the peripheral. A design that let those bits leak through would change the pad while the peripheral owns it. The bench also checks the pin-state slot after one edge and again after two edges, so a synchronizer with a stage missing or an extra stage shows up. Finally, the bench puts opposite levels on the pads and reads the latch slot. A design that returned pad levels from that slot would give the wrong value.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    parameter int GP_W = 8;
    parameter int GP_AW = 2;

    typedef enum logic [GP_AW-1:0] {
        SLOT_PSEL  = 2'd0,
        SLOT_STYLE = 2'd1,
        SLOT_LATCH = 2'd2,
        SLOT_PIN   = 2'd3
    } slot_e;

    typedef struct packed {
        logic oe;
        logic out;
    } pin_drive_t;

    // Per-pin resolution: peripheral ownership first, then drive style.
    function automatic pin_drive_t resolve_pin(
        input logic psel,
        input logic style_od,
        input logic latch,
        input logic p_out,
        input logic p_oe
    );
        pin_drive_t d;
        if (psel) begin
            d.oe  = p_oe;
            d.out = p_out;
        end else if (!style_od) begin
            d.oe  = 1'b1;
            d.out = latch;
        end else begin
            d.oe  = ~latch;
            d.out = 1'b0;
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_pkg::*;
#(
    parameter int W = GP_W,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

    // Cycles since reset, saturating, used to gate the latency check.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)               warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_chk
            p_sync_latency_r8: assert property (@(posedge clk) disable iff (rst)
                (warm >= 2'd2) |-> (sync_out == $past(async_in, 2)));
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = GP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  slot_e        sel,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_state,
    output logic [W-1:0] rdata,
    output logic [W-1:0] psel_q,
    output logic [W-1:0] style_q,
    output logic [W-1:0] latch_q
);
    localparam logic [W-1:0] PSEL_RST  = '0;
    localparam logic [W-1:0] STYLE_RST = '1;
    localparam logic [W-1:0] LATCH_RST = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            psel_q  <= PSEL_RST;
            style_q <= STYLE_RST;
            latch_q <= LATCH_RST;
        end else if (wr_en) begin
            case (sel)
                SLOT_PSEL:  psel_q  <= wdata;
                SLOT_STYLE: style_q <= wdata;
                SLOT_LATCH: latch_q <= wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SLOT_PSEL:  rdata = psel_q;
            SLOT_STYLE: rdata = style_q;
            SLOT_LATCH: rdata = latch_q;
            default:    rdata = pin_state;
        endcase
    end

    p_psel_write_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SLOT_PSEL) |=> (psel_q == $past(wdata)));

    p_latch_write_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SLOT_LATCH) |=> (latch_q == $past(wdata)));

    p_pin_slot_no_write_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SLOT_PIN) |=>
            ($stable(psel_q) && $stable(style_q) && $stable(latch_q)));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_pkg::*;
#(
    parameter int W = GP_W
) (
    input  logic [W-1:0] psel,
    input  logic [W-1:0] style_od,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] p_out,
    input  logic [W-1:0] p_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_pin
            pin_drive_t drv;
            always_comb begin
                drv = resolve_pin(psel[i], style_od[i], latch[i], p_out[i], p_oe[i]);
                pad_out[i] = drv.out;
                pad_oe[i]  = drv.oe;
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W = GP_W,
    parameter int AW = GP_AW,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic [W-1:0]  periph_out,
    input  logic [W-1:0]  periph_oe,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe
);
    logic [W-1:0] pin_state;
    logic [W-1:0] psel_q, style_q, latch_q;
    slot_e        sel;

    assign sel = slot_e'(addr);

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (pin_state)
    );

    gpio_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .sel       (sel),
        .wdata     (wdata),
        .pin_state (pin_state),
        .rdata     (rdata),
        .psel_q    (psel_q),
        .style_q   (style_q),
        .latch_q   (latch_q)
    );

    gpio_pad_mux #(.W(W)) u_mux (
        .psel     (psel_q),
        .style_od (style_q),
        .latch    (latch_q),
        .p_out    (periph_out),
        .p_oe     (periph_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    p_reset_hiz_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0));

    // All pins owned by the peripheral: pad follows only the peripheral.
    p_periph_owns_r6: assert property (@(posedge clk) disable iff (rst)
        ((&psel_q) && $stable(psel_q) && $stable(periph_out) && $stable(periph_oe))
            |-> ($stable(pad_out) && $stable(pad_oe)));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    localparam int CLK_P = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic [W-1:0] periph_out = '0;
    logic [W-1:0] periph_oe = '0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;

    always #(CLK_P/2) clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .periph_out(periph_out), .periph_oe(periph_oe),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef struct {
        string        req;
        int           what;   // 0 rdata, 1 pad_out, 2 pad_oe
        logic [W-1:0] exp;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;

    // Bench model of control state.
    logic [W-1:0] m_psel, m_style, m_latch;

    function automatic logic [W-1:0] exp_oe();
        return (m_psel & periph_oe) | (~m_psel & (~m_style | ~m_latch));
    endfunction
    function automatic logic [W-1:0] exp_out();
        return (m_psel & periph_out) | (~m_psel & ~m_style & m_latch);
    endfunction

    // Monitor: pops expectations and compares to live outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [W-1:0] act;
                it = q.pop_front();
                case (it.what)
                    0:       act = rdata;
                    1:       act = pad_out;
                    default: act = pad_oe;
                endcase
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.what, act, it.exp);
                end
            end
        end
    end

    task automatic push(input string req, input int what, input logic [W-1:0] e);
        item_t it;
        it.req = req; it.what = what; it.exp = e;
        q.push_back(it);
    endtask

    task automatic fire();
        #1;
        -> chk_ev;
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            2'd0: m_psel = d;
            2'd1: m_style = d;
            2'd2: m_latch = d;
            default: ;
        endcase
    endtask

    task automatic chk_rd(input logic [1:0] a, input logic [W-1:0] e, input string req);
        addr = a;
        push(req, 0, e);
        fire();
    endtask

    task automatic chk_pads(input string req);
        push(req, 1, exp_out());
        push(req, 2, exp_oe());
        fire();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_psel = '0; m_style = '1; m_latch = '1;
        @(negedge clk);
    endtask

    initial begin
        m_psel = '0; m_style = '1; m_latch = '1;
        do_reset();
        // R1: reset values and high-impedance pads
        chk_rd(2'd0, 8'h00, "R1");
        chk_rd(2'd1, 8'hFF, "R1");
        chk_rd(2'd2, 8'hFF, "R1");
        push("R1", 2, 8'h00); fire();

        // R9 / R3: push-pull on all pins
        wr(2'd1, 8'h00);
        wr(2'd2, 8'hA5);
        chk_rd(2'd1, 8'h00, "R9");
        chk_rd(2'd2, 8'hA5, "R9");
        push("R3", 1, 8'hA5); push("R3", 2, 8'hFF); fire();

        // R4 / R5: all open-drain
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h3C);
        push("R4", 1, 8'h00); push("R5", 2, 8'hC3); fire();

        // Mixed push-pull and open-drain
        wr(2'd1, 8'hF0);
        wr(2'd2, 8'h5A);
        chk_pads("R4");

        // R2: mixed peripheral and GPIO pins
        periph_out = 8'h96; periph_oe = 8'h3C;
        wr(2'd0, 8'h0F);
        chk_rd(2'd0, 8'h0F, "R9");
        chk_pads("R2");
        periph_out = 8'h69; periph_oe = 8'hC3;
        chk_pads("R2");

        // R6: peripheral owns everything; style/latch writes ignored at pads
        wr(2'd0, 8'hFF);
        chk_pads("R6");
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        push("R6", 1, 8'h69); push("R6", 2, 8'hC3); fire();
        chk_rd(2'd1, 8'h00, "R6");
        chk_rd(2'd2, 8'h00, "R6");
        wr(2'd0, 8'h00);
        push("R6", 1, 8'h00); push("R6", 2, 8'hFF); fire();

        // R7: latch readback independent of pads
        wr(2'd2, 8'hE1);
        pad_in = 8'h1E;
        repeat (3) @(negedge clk);
        chk_rd(2'd2, 8'hE1, "R7");

        // R8: two-edge synchronizer latency
        chk_rd(2'd3, 8'h1E, "R8");
        pad_in = 8'hC3;
        @(negedge clk);
        chk_rd(2'd3, 8'h1E, "R8");
        @(negedge clk);
        chk_rd(2'd3, 8'hC3, "R8");
        // R8 in peripheral mode
        wr(2'd0, 8'hFF);
        pad_in = 8'h81;
        repeat (2) @(negedge clk);
        chk_rd(2'd3, 8'h81, "R8");

        // R10: write to pin-state slot has no effect
        wr(2'd3, 8'h55);
        chk_rd(2'd0, 8'hFF, "R10");
        chk_rd(2'd1, 8'h00, "R10");
        chk_rd(2'd2, 8'hE1, "R10");
        chk_rd(2'd3, 8'h81, "R10");

        // R1: reset again from a busy state
        do_reset();
        chk_rd(2'd0, 8'h00, "R1");
        chk_rd(2'd2, 8'hFF, "R1");
        push("R1", 2, 8'h00); fire();

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule